// File: doc/BRIEF.md
# Chained DMA Channel Register Block

This block is the control side of a single DMA channel. Software programs it through a 32-bit register port that honours only full-word accesses. The port exposes a command/status word and five address registers: the current pointer, the limit, a chained start/stop pair, and a spare initial-pointer word. Writes to the command word do not store a value. Each written bit is a command that sets or clears one status flag.

While the channel is enabled, it offers one beat at a time on a valid/ready request port. The address is the current pointer. The requester holds `mem_valid` and `mem_addr` steady until `mem_ready` is sampled high in the same cycle. Each accepted beat moves the pointer forward by one word. A low `mem_ready` stalls the channel for as long as it stays low, and nothing is lost or repeated.

When the pointer reaches the limit, the buffer is complete and the channel raises an interrupt. If the chain flag was armed, the pointer and the limit reload from the start/stop pair, the chain flag disarms, and the channel carries on. Otherwise the channel stops.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `mem_valid` is 0.
- R2: Full-word writes store their value, and full-word reads return it, at these offsets:
  - current pointer at 0x4000
  - limit at 0x4004
  - chain start at 0x4008
  - chain stop at 0x400C
  - initial pointer at 0x4200
- R3: An access with `reg_size` other than 2'b10 (word) has no effect. A read at such a size returns 0, and a read at an unmapped offset returns 0.
- R4: A write to offset 0x0 sets status flags, which read back from offset 0x0:
  - bit 16 sets run, read back at bit 24
  - bit 17 sets chain-armed, read back at bit 25
  - bit 18 sets device-to-memory direction, read back at bit 18
  
  A zero in any of these command bits leaves the matching flag unchanged.
- R5: Writing bit 19 to offset 0x0 clears the done flag (read back at bit 27), and `irq` falls in the next cycle.
- R6: Writing bit 20 to offset 0x0 clears done, chain-armed, run and direction together. It wins over any set bit in the same write.
- R7: `mem_valid` is high exactly when run is set and the pointer differs from the limit. `mem_addr` is the pointer and `mem_dir` is the direction flag. Each cycle with `mem_valid` and `mem_ready` both high adds 4 to the pointer. While `mem_ready` is low, the address holds.
- R8: When an accepted beat brings the pointer equal to the limit, done is set and `irq` rises on the next cycle. If chain-armed is clear, run clears and `mem_valid` drops.
- R9: If chain-armed is set at completion, the pointer loads chain start and the limit loads chain stop. Chain-armed clears and run stays set.
- R10: `irq` follows the done flag. It stays high across unrelated register writes until a clear-done or reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_size | input | 2 | Access size code, 2'b10 = 32-bit word |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| mem_valid | output | 1 | Beat request valid |
| mem_ready | input | 1 | Beat accepted by the memory side |
| mem_addr | output | DATA_W | Beat address (current pointer) |
| mem_dir | output | 1 | 1 = device to memory |
| irq | output | 1 | Buffer-complete interrupt |

## Verification
The bench builds the block with its defaults: 16-bit offsets, 32-bit words and 4-byte beats. Buffers of one to three beats therefore reach completion and chaining within a few cycles. The same settings let the exact command-bit and status-bit positions be checked on every readback. Stalls under a held-low ready are exercised alongside a chain that runs two buffers back to back, with the direction flag set.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int CMD_RUN   = 16;
  localparam int CMD_CHAIN = 17;
  localparam int CMD_D2M   = 18;
  localparam int CMD_CLRD  = 19;
  localparam int CMD_RST   = 20;

  localparam int ST_RUN    = 24;
  localparam int ST_CHAIN  = 25;
  localparam int ST_DONE   = 27;
  localparam int ST_D2M    = 18;

  localparam int NREG      = 6;

  typedef enum logic [2:0] {
    R_CTRL = 3'd0, R_NEXT = 3'd1, R_LIM = 3'd2,
    R_START = 3'd3, R_STOP = 3'd4, R_INIT = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic run;
    logic chain;
    logic d2m;
    logic done;
  } chan_flags_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [NREG-1:0]   sel
);
  localparam logic [1:0] WORD = 2'b10;
  localparam logic [ADDR_W-1:0] OFFS [NREG] = '{
    ADDR_W'(16'h0000), ADDR_W'(16'h4000), ADDR_W'(16'h4004),
    ADDR_W'(16'h4008), ADDR_W'(16'h400C), ADDR_W'(16'h4200)
  };

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (size == WORD) && (addr == OFFS[i]);
  end
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [4:0]  cmd,
  input  logic        done_ev,
  output chan_flags_t flags
);
  chan_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (done_ev) begin
      nxt.done  = 1'b1;
      nxt.run   = flags.chain;
      nxt.chain = 1'b0;
    end
    if (cmd_wr) begin
      if (cmd[CMD_RUN-16])   nxt.run   = 1'b1;
      if (cmd[CMD_CHAIN-16]) nxt.chain = 1'b1;
      if (cmd[CMD_D2M-16])   nxt.d2m   = 1'b1;
      if (cmd[CMD_CLRD-16])  nxt.done  = 1'b0;
      if (cmd[CMD_RST-16])   nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/dma_ptr_engine.sv
module dma_ptr_engine
  import dma_chain_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              beat,
  input  logic              chain,
  output logic              done_ev,
  output logic [DATA_W-1:0] next_q,
  output logic [DATA_W-1:0] lim_q,
  output logic [DATA_W-1:0] start_q,
  output logic [DATA_W-1:0] stop_q,
  output logic [DATA_W-1:0] init_q
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(BEAT_BYTES);
  logic [DATA_W-1:0] adv;

  assign adv     = next_q + STEP;
  assign done_ev = beat && (adv == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0; lim_q <= '0; start_q <= '0; stop_q <= '0; init_q <= '0;
    end else begin
      if (done_ev && chain) begin
        next_q <= start_q;
        lim_q  <= stop_q;
      end else if (beat) begin
        next_q <= adv;
      end
      if (wsel[R_NEXT])  next_q  <= wdata;
      if (wsel[R_LIM])   lim_q   <= wdata;
      if (wsel[R_START]) start_q <= wdata;
      if (wsel[R_STOP])  stop_q  <= wdata;
      if (wsel[R_INIT])  init_q  <= wdata;
    end
  end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_size,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_dir,
  output logic              irq
);
  logic [NREG-1:0]   sel, wsel;
  chan_flags_t       flags;
  logic              beat, done_ev;
  logic [DATA_W-1:0] next_q, lim_q, start_q, stop_q, init_q, status;
  logic              run_q;

  dma_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .size(reg_size), .sel(sel)
  );

  assign wsel = reg_wr ? sel : '0;

  dma_chan_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wsel[R_CTRL]),
    .cmd(reg_wdata[CMD_RST:CMD_RUN]), .done_ev(done_ev), .flags(flags)
  );

  dma_ptr_engine #(.DATA_W(DATA_W), .BEAT_BYTES(BEAT_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(reg_wdata),
    .beat(beat), .chain(flags.chain), .done_ev(done_ev),
    .next_q(next_q), .lim_q(lim_q), .start_q(start_q),
    .stop_q(stop_q), .init_q(init_q)
  );

  assign run_q     = flags.run;
  assign mem_valid = flags.run && (next_q != lim_q);
  assign beat      = mem_valid && mem_ready;
  assign mem_addr  = next_q;
  assign mem_dir   = flags.d2m;
  assign irq       = flags.done;

  always_comb begin
    status           = '0;
    status[ST_RUN]   = flags.run;
    status[ST_CHAIN] = flags.chain;
    status[ST_DONE]  = flags.done;
    status[ST_D2M]   = flags.d2m;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (1'b1)
      sel[R_CTRL]:  reg_rdata = status;
      sel[R_NEXT]:  reg_rdata = next_q;
      sel[R_LIM]:   reg_rdata = lim_q;
      sel[R_START]: reg_rdata = start_q;
      sel[R_STOP]:  reg_rdata = stop_q;
      sel[R_INIT]:  reg_rdata = init_q;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chain_channel_chk.sv
module dma_chain_channel_chk #(
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic              irq,
  input logic              run_q,
  input logic [DATA_W-1:0] lim_q
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !reg_wr) |=> $stable(mem_addr));
  // R7
  valid_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> run_q);
  // R7
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !reg_wr &&
     (mem_addr + DATA_W'(BEAT_BYTES) != lim_q))
    |=> (mem_addr == $past(mem_addr) + DATA_W'(BEAT_BYTES)));
  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !reg_wr &&
     (mem_addr + DATA_W'(BEAT_BYTES) == lim_q)) |=> irq);
  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);
endmodule

bind dma_chain_channel dma_chain_channel_chk #(
  .DATA_W(DATA_W), .BEAT_BYTES(BEAT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .irq(irq),
  .run_q(run_q), .lim_q(lim_q)
);

// File: tb/dma_chain_channel_test.sv
module dma_chain_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 0, rst_n = 0;
  logic          reg_wr = 0;
  logic [1:0]    reg_size = 2'b10;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          mem_valid, mem_ready = 0, mem_dir, irq;
  logic [DW-1:0] mem_addr;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_size(reg_size),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_dir(mem_dir), .irq(irq)
  );

  // vector: {req number, offset, write data, expected readback}
  localparam int NV = 11;
  localparam logic [87:0] VEC [NV] = '{
    {8'd2, 16'h4000, 32'h1000_0000, 32'h1000_0000},  // R2 pointer
    {8'd2, 16'h4004, 32'hA5A5_0004, 32'hA5A5_0004},  // R2 limit
    {8'd2, 16'h4008, 32'h0000_0300, 32'h0000_0300},  // R2 chain start
    {8'd2, 16'h400C, 32'hFFFF_FFFC, 32'hFFFF_FFFC},  // R2 chain stop
    {8'd2, 16'h4200, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2 initial
    {8'd4, 16'h0000, 32'h0001_0000, 32'h0100_0000},  // R4 run
    {8'd4, 16'h0000, 32'h0002_0000, 32'h0300_0000},  // R4 chain
    {8'd4, 16'h0000, 32'h0004_0000, 32'h0304_0000},  // R4 direction
    {8'd4, 16'h0000, 32'h0000_0000, 32'h0304_0000},  // R4 no change
    {8'd6, 16'h0000, 32'h0010_0000, 32'h0000_0000},  // R6 reset cmd
    {8'd6, 16'h0000, 32'h0017_0000, 32'h0000_0000}   // R6 wins over sets
  };

  task automatic chk(input string req, input logic [DW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [1:0] sz = 2'b10);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_size = sz; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_size = 2'b10;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d,
                    input logic [1:0] sz = 2'b10);
    reg_addr = a; reg_size = sz;
    #1 d = reg_rdata;
    reg_size = 2'b10;
  endtask

  task automatic beats(input int n);
    @(negedge clk);
    mem_ready = 1;
    repeat (n) @(negedge clk);
    mem_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(16'h0000, v); chk("R1 ctrl", v, 0);
    rd(16'h4000, v); chk("R1 next", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 valid", {31'b0, mem_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:64], VEC[i][63:32]);
      rd(VEC[i][79:64], v);
      chk($sformatf("R%0d vec%0d", VEC[i][87:80], i), v, VEC[i][31:0]);
    end

    // R3 non-word accesses and unmapped reads
    wr(16'h4000, 32'h1234_5678, 2'b00);
    rd(16'h4000, v); chk("R3 byte write ignored", v, 32'h1000_0000);
    rd(16'h4000, v, 2'b01); chk("R3 half read zero", v, 0);
    rd(16'h1234, v); chk("R3 unmapped read", v, 0);

    // R7/R8 single buffer of three beats with a stall
    wr(16'h4000, 32'h100); wr(16'h4004, 32'h10C);
    wr(16'h0000, 32'h0001_0000);
    chk("R7 valid", {31'b0, mem_valid}, 1);
    repeat (2) @(negedge clk);
    chk("R7 stall holds addr", mem_addr, 32'h100);
    beats(1);
    chk("R7 one beat", mem_addr, 32'h104);
    beats(2);
    chk("R8 irq", {31'b0, irq}, 1);
    chk("R8 valid drops", {31'b0, mem_valid}, 0);
    rd(16'h0000, v); chk("R8 status", v, 32'h0800_0000);
    rd(16'h4000, v); chk("R8 pointer at limit", v, 32'h10C);

    // R5 clear done
    wr(16'h0000, 32'h0008_0000);
    chk("R5 irq low", {31'b0, irq}, 0);
    rd(16'h0000, v); chk("R5 status", v, 0);

    // R9 chaining with direction set
    wr(16'h4000, 32'h200); wr(16'h4004, 32'h204);
    wr(16'h4008, 32'h300); wr(16'h400C, 32'h308);
    wr(16'h0000, 32'h0007_0000);
    chk("R7 dir", {31'b0, mem_dir}, 1);
    beats(1);
    rd(16'h0000, v); chk("R9 status after chain", v, 32'h0904_0000);
    rd(16'h4000, v); chk("R9 pointer reload", v, 32'h300);
    rd(16'h4004, v); chk("R9 limit reload", v, 32'h308);
    chk("R9 still valid", {31'b0, mem_valid}, 1);
    beats(2);
    rd(16'h0000, v); chk("R9 second buffer stops", v, 32'h0804_0000);
    chk("R9 valid drops", {31'b0, mem_valid}, 0);

    // R10 irq sticky across unrelated writes, dropped by reset command
    wr(16'h4200, 32'h5);
    wr(16'h0000, 32'h0);
    chk("R10 irq held", {31'b0, irq}, 1);
    wr(16'h0000, 32'h0010_0000);
    chk("R10 irq cleared by reset cmd", {31'b0, irq}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule